// File: doc/BRIEF.md
# Dual-Width Serial Flash Read Responder

This block acts as the device end of a serial flash, limited to its two double-width read commands. It watches a chip select, a serial clock and two data lines. It decodes the command byte and then collects a start address. After a command-dependent number of wait clocks it streams bytes from an internal byte array, two bits per serial clock. The address advances after every byte and wraps at the top of the array. The array is loaded through a plain synchronous write port, so nothing has to be read from a file.

Every pin is sampled on a fast system clock. A serial clock edge is seen as a change from the previous sample. The data lines appear as separate input values, output values and per-line output enables, which an I/O ring or bench combines into bidirectional pins. Command 3Bh takes its address one bit per clock on line 0. Command BBh takes it two bits per clock on both lines. Any other command makes the block stay silent until chip select is released.

Top module: `dspi_read_responder`

## Requirements
- R1: While `cs_n` is high, both output enables are 0 at once, and all command state returns to its start. A read that is aborted mid-byte does not disturb the next transaction.
- R2: After `cs_n` falls, the first 8 rising SCK edges sample `io0_in` as the command byte, most significant bit first.
- R3: With command 3Bh, the next 24 rising edges sample address bits A23 down to A0 on `io0_in`. Eight dummy clocks follow, and the first data pair appears on the falling edge after the last dummy rising edge.
- R4: With command BBh, the next 12 rising edges sample two address bits each: the odd bit (A23, A21 … A1) on `io1_in` and the even bit (A22, A20 … A0) on `io0_in`. Four dummy clocks follow. Neither line is driven at any point during the dummy clocks.
- R5: Output values change only on falling SCK edges. Each byte goes out as four pairs, highest pair first: bits 7, 5, 3, 1 on `io1_out` and bits 6, 4, 2, 0 on `io0_out`. Both enables are 1 from the first data falling edge onward.
- R6: After each byte the address increments by one. From the highest array address (2^ADDR_W − 1) it wraps to 0 and output continues.
- R7: Address bits at and above ADDR_W are ignored.
- R8: Any other command byte leaves both enables at 0 for the rest of the transaction, whatever is clocked in afterwards.
- R9: A write through `mem_we`, `mem_waddr` and `mem_wdata` stores the byte on the next `clk` rising edge. Later reads return it.
- R10: While `rst_n` is low, both output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every pin |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| io0_in | input | 1 | Value seen on data line 0 |
| io1_in | input | 1 | Value seen on data line 1 |
| io0_out | output | 1 | Value driven on data line 0 (even bits) |
| io1_out | output | 1 | Value driven on data line 1 (odd bits) |
| io0_oe | output | 1 | Output enable for data line 0 |
| io1_oe | output | 1 | Output enable for data line 1 |
| mem_we | input | 1 | Array write strobe |
| mem_waddr | input | ADDR_W | Array write address |
| mem_wdata | input | 8 | Array write data |

## Verification
The assertions assume that SCK stays at each level for at least three `clk` cycles. They also assume that the data inputs and `cs_n` change only while SCK is low, so each serial edge is seen once and the byte read is ready before the first data falling edge. The bench holds every SCK level for four system clocks and changes host data, and chip select, only in the low phase. It drives SCK low at select (mode 0). Under these conditions the output-stability and address-step properties relate cleanly to the detected edges.

// File: rtl/dspi_read_responder.sv
module dspi_read_responder #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              io0_in,
  input  logic              io1_in,
  output logic              io0_out,
  output logic              io1_out,
  output logic              io0_oe,
  output logic              io1_oe,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_waddr,
  input  logic [7:0]        mem_wdata
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] ONE = 1;
  localparam logic [7:0] CMD_SINGLE_ADDR = 8'h3B;
  localparam logic [7:0] CMD_DUAL_ADDR   = 8'hBB;

  typedef enum logic [2:0] {P_OPC, P_ADDR, P_DUMMY, P_DATA, P_IDLE} phase_t;

  phase_t            phase;
  logic              dual, sck_q, drv;
  logic [4:0]        cnt;
  logic [6:0]        opc;
  logic [1:0]        pc;
  logic [7:0]        shreg, rdata;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        mem [DEPTH];

  logic              sck_rise, sck_fall;
  logic [4:0]        addr_last, dummy_last;
  logic [7:0]        opc_next;
  logic [ADDR_W-1:0] addr_next;

  assign sck_rise   = ~cs_n & sck & ~sck_q;
  assign sck_fall   = ~cs_n & ~sck & sck_q;
  assign addr_last  = dual ? 5'd11 : 5'd23;
  assign dummy_last = dual ? 5'd3 : 5'd7;
  assign opc_next   = {opc, io0_in};
  assign addr_next  = dual ? {addr[ADDR_W-3:0], io1_in, io0_in} : {addr[ADDR_W-2:0], io0_in};
  assign io0_oe     = drv & ~cs_n;
  assign io1_oe     = drv & ~cs_n;

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_waddr] <= mem_wdata;
    rdata <= mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_OPC; dual <= 1'b0; cnt <= '0; opc <= '0; addr <= '0;
      drv <= 1'b0; pc <= '0; shreg <= '0; io0_out <= 1'b0; io1_out <= 1'b0;
    end else if (cs_n) begin
      phase <= P_OPC; dual <= 1'b0; cnt <= '0; opc <= '0; addr <= '0;
      drv <= 1'b0; pc <= '0; shreg <= '0; io0_out <= 1'b0; io1_out <= 1'b0;
    end else begin
      if (sck_rise) begin
        case (phase)
          P_OPC: begin
            opc <= opc_next[6:0];
            cnt <= cnt + 5'd1;
            if (cnt == 5'd7) begin
              cnt <= '0;
              if (opc_next == CMD_SINGLE_ADDR) begin
                phase <= P_ADDR; dual <= 1'b0;
              end else if (opc_next == CMD_DUAL_ADDR) begin
                phase <= P_ADDR; dual <= 1'b1;
              end else begin
                phase <= P_IDLE;
              end
            end
          end
          P_ADDR: begin
            addr <= addr_next;
            cnt  <= cnt + 5'd1;
            if (cnt == addr_last) begin
              cnt <= '0; phase <= P_DUMMY;
            end
          end
          P_DUMMY: begin
            cnt <= cnt + 5'd1;
            if (cnt == dummy_last) begin
              cnt <= '0; phase <= P_DATA;
            end
          end
          default: ;
        endcase
      end
      if (sck_fall && phase == P_DATA) begin
        drv <= 1'b1;
        pc  <= pc + 2'd1;
        if (pc == 2'd0) begin
          {io1_out, io0_out} <= rdata[7:6];
          shreg <= {rdata[5:0], 2'b00};
          addr  <= addr + ONE;
        end else begin
          {io1_out, io0_out} <= shreg[7:6];
          shreg <= {shreg[5:0], 2'b00};
        end
      end
    end
  end

  AST_OE_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (io0_oe || io1_oe) |-> (phase == P_DATA)) else $error("enable outside data phase"); // R8

  AST_DUMMY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_DUMMY) |-> !(io0_oe || io1_oe)) else $error("line driven in dummy phase"); // R4

  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n || cs_n)
    !sck_fall |=> $stable({io1_out, io0_out})) else $error("output moved without falling edge"); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n || cs_n)
    (sck_fall && phase == P_DATA && pc == 2'd0) |=> (addr == $past(addr) + ONE)) else $error("address did not advance"); // R6

endmodule

// File: tb/dspi_read_responder_bench.sv
module dspi_read_responder_bench;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HALF   = 4;
  localparam int NVEC   = 6;
  localparam logic [39:0] VEC [NVEC] = '{
    40'h3B00000004, 40'hBB00001005, 40'h3B0003FE04,
    40'hBB0003FD06, 40'h3BFFF12303, 40'hBB5A520003 };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cs_n, sck, h0, h1;
  logic io0_out, io1_out, io0_oe, io1_oe;
  logic mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0] mem_wdata;
  int checks = 0, fails = 0;
  bit done = 0;

  dspi_read_responder #(.ADDR_W(ADDR_W)) u_dspi_read_responder (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .io0_in(h0), .io1_in(h1),
    .io0_out(io0_out), .io1_out(io1_out), .io0_oe(io0_oe), .io1_oe(io1_oe),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata));

  function automatic logic [7:0] pattern(int a);
    return 8'((a * 37 + 11) ^ (a >> 4));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic b1, logic b0);
    h1 = b1; h0 = b0;
    repeat (HALF) @(negedge clk);
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic start_cmd(logic [7:0] op);
    cs_n = 1'b0; sck = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 7; i >= 0; i--) send(1'b0, op[i]);
  endtask

  task automatic finish_cmd;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic send_addr_dummy(logic [7:0] op, logic [23:0] a);
    int nd;
    if (op == 8'h3B) begin
      for (int i = 23; i >= 0; i--) send(1'b0, a[i]);
      nd = 8;
    end else begin
      for (int i = 23; i > 0; i -= 2) send(a[i], a[i-1]);
      nd = 4;
    end
    for (int d = 0; d < nd; d++) begin
      h0 = 1'b1; h1 = 1'b0;
      repeat (HALF) @(negedge clk);
      check(op == 8'hBB ? "R4 dummy low undriven" : "R3 dummy low undriven", {io1_oe, io0_oe}, 2'b00);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      check(op == 8'hBB ? "R4 dummy high undriven" : "R3 dummy high undriven", {io1_oe, io0_oe}, 2'b00);
      sck = 1'b0;
    end
  endtask

  task automatic read_byte(string tag, logic [7:0] exp, int stop_after);
    logic [7:0] got = '0;
    for (int p = 0; p < 4; p++) begin
      if (p == stop_after) return;
      repeat (HALF) @(negedge clk);
      if (p == 0) check("R5 enables on", {io1_oe, io0_oe}, 2'b11);
      got = {got[5:0], io1_out, io0_out};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      check("R5 pair held across rising edge", {io1_out, io0_out}, got[1:0]);
      sck = 1'b0;
    end
    check(tag, got, exp);
  endtask

  task automatic burst(logic [7:0] op, logic [23:0] a, int n, string tag);
    int base = int'(a[ADDR_W-1:0]);
    start_cmd(op);
    send_addr_dummy(op, a);
    for (int b = 0; b < n; b++) read_byte(tag, pattern((base + b) % DEPTH), 4);
    finish_cmd();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; h0 = 1'b0; h1 = 1'b0;
    mem_we = 1'b0; mem_waddr = '0; mem_wdata = '0;
    repeat (3) @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    check("R10 enables low in reset", {io1_oe, io0_oe}, 2'b00);
    cs_n = 1'b1;
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      mem_we = 1'b1; mem_waddr = ADDR_W'(i); mem_wdata = pattern(i);
      @(negedge clk);
    end
    mem_we = 1'b0;
    check("R1 enables low when deselected", {io1_oe, io0_oe}, 2'b00);

    // R2 R3 R4 R5 R6 R7 table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] op = VEC[v][39:32];
      burst(op, VEC[v][31:8], int'(VEC[v][7:0]),
            op == 8'h3B ? "R2 R3 R6 R7 data" : "R2 R4 R6 R7 data");
    end

    // R8 unknown commands, then recovery
    for (int k = 0; k < 2; k++) begin
      start_cmd(k == 0 ? 8'h03 : 8'h3A);
      for (int i = 0; i < 30; i++) begin
        send(i[0], i[1]);
        check("R8 ignored command stays undriven", {io1_oe, io0_oe}, 2'b00);
      end
      finish_cmd();
    end
    burst(8'hBB, 24'h000100, 2, "R8 recovery after ignored command");

    // R1 abort mid-byte
    start_cmd(8'h3B);
    send_addr_dummy(8'h3B, 24'h000020);
    read_byte("R1 first byte before abort", pattern(32), 4);
    read_byte("R1 partial", 8'h00, 2);
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    #1;
    check("R1 enables drop with cs_n", {io1_oe, io0_oe}, 2'b00);
    repeat (2 * HALF) @(negedge clk);
    burst(8'h3B, 24'h000040, 2, "R1 clean read after abort");

    // R9 backdoor overwrite
    mem_we = 1'b1; mem_waddr = ADDR_W'(5); mem_wdata = 8'hC6;
    @(negedge clk);
    mem_we = 1'b0;
    start_cmd(8'hBB);
    send_addr_dummy(8'hBB, 24'h000005);
    read_byte("R9 written byte read back", 8'hC6, 4);
    read_byte("R9 neighbour unchanged", pattern(6), 4);
    finish_cmd();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule